// File: doc/BRIEF.md
# Power-Down Wakeup Controller

This block owns the power-down state of a small microcontroller core. When software writes the power-down bit, the block turns off the oscillator enable. It also gates the CPU clock and the peripheral clock. Two active-low external interrupt lines can end power-down. A line counts only when its enable bit is set and it is configured as level-sensitive. Edge-configured or disabled lines are ignored while the core sleeps.

On a qualified wakeup, the block takes these steps in order:

1. It clears the power-down bit and raises the oscillator enable at once.
2. It counts a programmable number of stabilisation cycles with the clocks still gated.
3. It ungates both clocks and pulses `wake_pending` for one cycle, with a one-hot code of the input that caused the wakeup. The interrupt controller uses this to run that input's service routine first.

CPU execution (`cpu_run`) stays held after the clocks return, until the causing input is released. If the input is released during the stabilisation count, the count still runs to its end.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After reset the block is awake: `pd_bit`=0, `osc_en`=1, `cpu_clk_en`=1, `per_clk_en`=1, `cpu_run`=1, `wake_pending`=0.
- R2: A `pd_set` pulse sampled while awake makes `pd_bit`=1 and drives `osc_en`, `cpu_clk_en`, `per_clk_en` and `cpu_run` to 0 from the next cycle on.
- R3: During power-down, input i (bit i of `int_n`) wakes the block only when `int_n[i]`=0, `int_en[i]`=1 and `int_level[i]`=1 (1 means level-sensitive). Any other combination leaves every output unchanged indefinitely.
- R4: The cycle after a qualified wake is sampled, `pd_bit`=0 and `osc_en`=1, while both clock enables stay 0.
- R5: Both clock enables rise exactly `stab_count`+1 cycles after `osc_en` rises, and they never rise while `osc_en` is 0.
- R6: In the first cycle with clocks restored, `wake_pending` is 1 for exactly one cycle. `wake_src` is then one-hot, with bit i set for the causing input. If both inputs qualify in the same cycle, input 0 wins (`wake_src`=2'b01).
- R7: `cpu_run` stays 0 while the causing input is still low after the clocks return. It rises one cycle after the input is sampled high.
- R8: If the causing input is released before the count ends, the count still completes. `cpu_run` then rises one cycle after the clock enables.
- R9: `pd_set` has no effect unless the block is awake, and interrupt inputs have no effect while awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (restarted oscillator domain) |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_set | input | 1 | Software write of 1 to the power-down bit |
| int_n | input | 2 | Active-low external interrupt lines |
| int_en | input | 2 | Per-line interrupt enable |
| int_level | input | 2 | Per-line trigger type, 1 = level-sensitive |
| stab_count | input | CW | Stabilisation cycles minus one |
| pd_bit | output | 1 | Power-down bit state |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| cpu_run | output | 1 | CPU execution release |
| wake_pending | output | 1 | One-cycle wakeup notification |
| wake_src | output | 2 | One-hot wakeup source |

## Verification
The assertions check these invariants on every cycle:
- the power-down bit and a running oscillator exclude each other;
- clock enables only appear with the oscillator on;
- the CPU stays held while the causing line is low;
- the wakeup notice is a lone one-hot pulse;
- a late `pd_set` cannot re-enter power-down.

Only the bench scenarios can show the rest:
- the exact stabilisation length for a range of counts;
- the rejection of edge-configured and disabled lines;
- the input-0 priority;
- release of the CPU both before and after the count ends.

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_set,
  input  logic [1:0]    int_n,
  input  logic [1:0]    int_en,
  input  logic [1:0]    int_level,
  input  logic [CW-1:0] stab_count,
  output logic          pd_bit,
  output logic          osc_en,
  output logic          cpu_clk_en,
  output logic          per_clk_en,
  output logic          cpu_run,
  output logic          wake_pending,
  output logic [1:0]    wake_src
);
  typedef enum logic [1:0] {S_RUN, S_PD, S_STAB, S_HOLD} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [1:0]    src;
  logic [1:0]    qual;
  logic          done;

  assign qual = ~int_n & int_en & int_level;
  assign done = (state == S_STAB) && (cnt == stab_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_RUN;
      cnt          <= '0;
      src          <= '0;
      wake_pending <= 1'b0;
    end else begin
      wake_pending <= done;
      case (state)
        S_RUN:  if (pd_set) state <= S_PD;
        S_PD:   if (|qual) begin
                  state <= S_STAB;
                  cnt   <= '0;
                  src   <= qual & (~qual + 2'd1);
                end
        S_STAB: if (done) state <= S_HOLD;
                else      cnt   <= cnt + 1'b1;
        S_HOLD: if ((src & ~int_n) == 2'b00) state <= S_RUN;
        default: state <= S_RUN;
      endcase
    end
  end

  assign pd_bit     = (state == S_PD);
  assign osc_en     = (state != S_PD);
  assign cpu_clk_en = (state == S_RUN) || (state == S_HOLD);
  assign per_clk_en = cpu_clk_en;
  assign cpu_run    = (state == S_RUN);
  assign wake_src   = src;

  // R2
  pd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_bit |-> (!osc_en && !cpu_clk_en && !per_clk_en && !cpu_run));
  // R5
  gate_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en || per_clk_en) |-> osc_en);
  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && (src & ~int_n) != 2'b00) |=> !cpu_run);
  // R6
  pulse_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pending |-> ($onehot(wake_src) && cpu_clk_en && !cpu_run));
  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pending |=> !wake_pending);
  // R9
  late_pdset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_RUN && !pd_bit) |=> !pd_bit);
endmodule

// File: tb/test_pd_wake_ctrl.sv
module test_pd_wake_ctrl;
  localparam int CW = 16;
  logic clk = 0, rst_n = 0, pd_set = 0;
  logic [1:0] int_n = 2'b11, int_en = 0, int_level = 0;
  logic [CW-1:0] stab_count = 0;
  logic pd_bit, osc_en, cpu_clk_en, per_clk_en, cpu_run, wake_pending;
  logic [1:0] wake_src;
  int errors = 0, checks = 0;

  pd_wake_ctrl #(.CW(CW)) i_pd_wake_ctrl (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] outs_awake();
    return 5'b01111;
  endfunction
  function automatic logic [4:0] outs_now();
    return {pd_bit, osc_en, cpu_clk_en, per_clk_en, cpu_run};
  endfunction
  function automatic logic [1:0] pick(input logic [1:0] low, en, lv);
    logic [1:0] q = low & en & lv;
    return q & (~q + 2'd1);
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic enter_pd();
    pd_set = 1; tick(); pd_set = 0;
    chk(outs_now() == 5'b10000, "R2", outs_now(), 5'b10000);
  endtask

  // wake with lines in mask held low; release after rel cycles counted from osc_en rise
  task automatic wake(input logic [1:0] mask, input int n, input int rel, input string tag);
    int c, last, rise_at;
    logic [1:0] exp_src;
    exp_src = pick(mask, int_en, int_level);
    stab_count = CW'(n);
    int_n = ~mask;
    tick();
    chk(outs_now() == 5'b01000, "R4", outs_now(), 5'b01000);
    last = ((n + 2) > (rel + 1)) ? n + 2 : rel + 1;
    rise_at = -1;
    for (c = 1; c <= last + 1; c++) begin
      if (c - 1 == rel) int_n = 2'b11;
      tick();
      if (cpu_clk_en && rise_at < 0) rise_at = c;
      chk(cpu_clk_en == (c >= n + 1), "R5", cpu_clk_en, c >= n + 1);
      chk(wake_pending == (c == n + 1), "R6", wake_pending, c == n + 1);
      if (c == n + 1) chk(wake_src == exp_src, "R6", wake_src, exp_src);
      chk(cpu_run == (c >= last), tag, cpu_run, c >= last);
    end
    chk(rise_at == n + 1, "R5", rise_at, n + 1);
  endtask

  initial begin
    int seed;
    seed = 11;
    void'($urandom(seed));
    #23 rst_n = 1;
    tick();
    chk(outs_now() == outs_awake() && !wake_pending, "R1", outs_now(), outs_awake());

    // R9: interrupts while awake
    int_en = 2'b11; int_level = 2'b11; int_n = 2'b00;
    repeat (4) begin tick(); chk(outs_now() == outs_awake(), "R9", outs_now(), outs_awake()); end
    int_n = 2'b11; tick();

    // directed: zero count, release late
    enter_pd(); wake(2'b01, 0, 5, "R7");
    // directed: both valid, input 0 priority
    enter_pd(); wake(2'b11, 3, 6, "R7");
    // directed: input 1 only, early release
    enter_pd(); wake(2'b10, 12, 2, "R8");

    // R3: disabled or edge-configured lines ignored
    int_en = 2'b01; int_level = 2'b10;
    enter_pd();
    int_n = 2'b00;
    repeat (10) begin tick(); chk(outs_now() == 5'b10000, "R3", outs_now(), 5'b10000); end
    int_n = 2'b11;
    int_en = 2'b11; int_level = 2'b11;
    wake(2'b10, 2, 4, "R7");

    // R9: pd_set during stabilisation and hold
    enter_pd();
    stab_count = 4; int_n = 2'b10; tick();
    pd_set = 1; tick(); pd_set = 0;
    chk(pd_bit == 0 && osc_en, "R9", pd_bit, 0);
    repeat (6) tick();
    pd_set = 1; tick(); pd_set = 0;
    chk(pd_bit == 0 && cpu_clk_en && !cpu_run, "R9", outs_now(), 5'b01110);
    int_n = 2'b11; tick();
    chk(cpu_run == 1, "R7", cpu_run, 1);
    tick();
    chk(outs_now() == outs_awake(), "R9", outs_now(), outs_awake());

    // random trials
    for (int t = 0; t < 60; t++) begin
      logic [1:0] m, e, l;
      int n, r;
      e = 2'($urandom); l = 2'($urandom); m = 2'($urandom_range(1, 3));
      n = $urandom_range(0, 20); r = $urandom_range(0, 25);
      int_en = e; int_level = l;
      enter_pd();
      if ((m & e & l) != 0) wake(m, n, r, (r < n + 1) ? "R8" : "R7");
      else begin
        int_n = ~m;
        repeat (5) begin tick(); chk(outs_now() == 5'b10000, "R3", outs_now(), 5'b10000); end
        int_n = 2'b11; int_en = 2'b11; int_level = 2'b11;
        wake(2'b01, n, r, "R7");
      end
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule